// File: doc/BRIEF.md
# Multi-Slave SPI Master Controller

This block is an SPI master for a bus that carries several slaves. Each slave has its own active-low select line. Each slave also has a stored setting made of a clock polarity, a clock phase and a character length. A host fills this table through a small write port, one slave per write. It then starts a transfer by naming a slave, giving a transmit word and giving a clock divider value.

When a transfer is accepted, the controller first moves the serial clock to the idle level that the target slave's polarity calls for. Only then does it drive that slave's select low. It shifts the character out most significant bit first on `mosi` and takes in `miso` at the same time, because every transfer is full duplex. It then releases the select and presents the received word with a one-cycle `done` pulse. The master alone generates the serial clock, at a fixed rate derived from the system clock. There is no acknowledgement and no flow control.

Top module: `spi_multi_master`

## Requirements
- R1: During and right after reset, every `cs_n` line is high, `sclk`, `mosi`, `busy` and `done` are low, and `rx_data` is zero.
- R2: When `cfg_we` is high at a clock edge, the entry for slave `cfg_sel` takes `cfg_cpol`, `cfg_cpha` and `cfg_len`, and the new entry applies to requests sampled at later edges. A length below 4 is stored as 4 and a length above 16 is stored as 16. After reset, every entry is polarity 0, phase 0, 16 bits.
- R3: A `req` sampled while `busy` is low is accepted. In the next cycle, `busy` is high, `sclk` equals the target's polarity and all selects are still high. In the cycle after that, only `cs_n[req_sel]` goes low. At most one select is ever low, and only while `busy` is high.
- R4: The serial clock half period is H = `clk_div`+1 system cycles, so the smallest ratio is 2. The first `sclk` edge comes H cycles after the select falls. Later edges are H cycles apart, and a transfer of L bits has exactly 2L edges.
- R5: `mosi` carries the first bit from the cycle the select falls. With phase 0, `miso` is sampled on the 1st, 3rd, ... edges and `mosi` advances on the 2nd, 4th, ... edges. With phase 1, `mosi` advances on the 3rd, 5th, ... edges and `miso` is sampled on the 2nd, 4th, ... edges. `mosi` is low whenever no select is low.
- R6: Bits are sent and received most significant first. Bits of `req_tx` at or above position L are never sent. `rx_data` holds the L received bits in its low positions, with zeros above them.
- R7: H cycles after the last edge, the select returns high. In that same cycle `busy` falls, `done` is high for exactly one cycle and `rx_data` takes the received word. `rx_data` then holds until the next `done`.
- R8: A `req` sampled while `busy` is high has no effect on selects, clock, data or the result.
- R9: When no select is low, `sclk` holds the polarity of the slave of the most recent transfer. The only exception is the single move to the new target's polarity in the first cycle of a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the slave setting table |
| cfg_sel | input | SEL_W | Slave whose entry is written |
| cfg_cpol | input | 1 | Clock polarity to store |
| cfg_cpha | input | 1 | Clock phase to store |
| cfg_len | input | LEN_W | Character length to store (clamped to 4..16) |
| req | input | 1 | Transfer request |
| req_sel | input | SEL_W | Target slave of the request |
| req_tx | input | 16 | Transmit word, right-aligned |
| clk_div | input | DIV_W | Half-period of the serial clock minus one, in system cycles |
| miso | input | 1 | Serial data from the selected slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the selected slave |
| cs_n | output | N_SLV | Active-low select, one per slave |
| busy | output | 1 | High from acceptance until the select is released |
| done | output | 1 | One-cycle pulse with the received word |
| rx_data | output | 16 | Received word, right-aligned |

## Verification
The bench runs all four clock modes with different lengths and divider values, including ratio 2, where an edge falls on every cycle. A swapped sample edge would show up as a shifted or corrupted received word, and a missing setup cycle would show up as `sclk` moving while a select is already low. Lengths of 2 and 20 are written to check clamping: a missing clamp would give the wrong number of edges and a misplaced `mosi` bit. Requests raised in the middle of a transfer, and a request held high so that it lands in the `done` cycle, check that a busy controller does not retarget its select and does not lose the next transfer. A configuration write in the same cycle as a request checks that the old entry is used.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;

    localparam int MAX_WORD = 16;
    localparam int MIN_WORD = 4;
    localparam int LEN_W    = $clog2(MAX_WORD + 1);
    localparam int ECNT_W   = LEN_W + 1;

    typedef struct packed {
        logic             cpol;
        logic             cpha;
        logic [LEN_W-1:0] len;
    } slv_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_END
    } eng_st_t;

endpackage

// File: rtl/spi_mm_cfg_tbl.sv
module spi_mm_cfg_tbl
    import spi_mm_pkg::*;
#(
    parameter int N_SLV = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] wsel,
    input  slv_cfg_t         wcfg,
    input  logic [SEL_W-1:0] rsel,
    output slv_cfg_t         rcfg
);

    slv_cfg_t wclamp;
    slv_cfg_t tbl_q [N_SLV];

    // Clamp the length into the legal character range before storing it.
    always_comb begin
        wclamp = wcfg;
        if (wcfg.len < LEN_W'(MIN_WORD)) begin
            wclamp.len = LEN_W'(MIN_WORD);
        end else if (wcfg.len > LEN_W'(MAX_WORD)) begin
            wclamp.len = LEN_W'(MAX_WORD);
        end
    end

    for (genvar i = 0; i < N_SLV; i++) begin : g_ent
        slv_cfg_t ent_d;

        always_comb begin
            ent_d = tbl_q[i];
            if (we && (wsel == SEL_W'(i))) begin
                ent_d = wclamp;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tbl_q[i] <= '{cpol: 1'b0, cpha: 1'b0, len: LEN_W'(MAX_WORD)};
            end else begin
                tbl_q[i] <= ent_d;
            end
        end
    end

    // Read port: entry of the requested slave, from the registered table.
    always_comb begin
        rcfg = tbl_q[0];
        for (int i = 0; i < N_SLV; i++) begin
            if (rsel == SEL_W'(i)) begin
                rcfg = tbl_q[i];
            end
        end
    end

endmodule

// File: rtl/spi_mm_csdec.sv
module spi_mm_csdec #(
    parameter int N_SLV = 4,
    parameter int SEL_W = 2
) (
    input  logic             act,
    input  logic [SEL_W-1:0] sel,
    output logic [N_SLV-1:0] cs_n
);

    for (genvar i = 0; i < N_SLV; i++) begin : g_cs
        assign cs_n[i] = !(act && (sel == SEL_W'(i)));
    end

endmodule

// File: rtl/spi_mm_engine.sv
module spi_mm_engine
    import spi_mm_pkg::*;
#(
    parameter int SEL_W = 2,
    parameter int DIV_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [SEL_W-1:0]    start_sel,
    input  slv_cfg_t            start_cfg,
    input  logic [MAX_WORD-1:0] start_tx,
    input  logic [DIV_W-1:0]    start_div,
    input  logic                miso,
    output logic                sclk,
    output logic                mosi,
    output logic                busy,
    output logic                done,
    output logic [MAX_WORD-1:0] rx_data,
    output logic                cs_act,
    output logic [SEL_W-1:0]    cs_sel
);

    typedef struct packed {
        eng_st_t             st;
        logic [SEL_W-1:0]    sel;
        logic                cpol;
        logic                cpha;
        logic [LEN_W-1:0]    len;
        logic [DIV_W-1:0]    half;
        logic [DIV_W-1:0]    hcnt;
        logic [ECNT_W-1:0]   ecnt;
        logic [MAX_WORD-1:0] sh;
        logic [MAX_WORD-1:0] rx;
        logic [MAX_WORD-1:0] rxo;
        logic                sclk;
        logic                busy;
        logic                done;
    } eng_t;

    eng_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st   = ST_SETUP;
                    d.sel  = start_sel;
                    d.cpol = start_cfg.cpol;
                    d.cpha = start_cfg.cpha;
                    d.len  = start_cfg.len;
                    d.half = start_div;
                    d.hcnt = start_div;
                    d.ecnt = '0;
                    // Left-align the character so the MSB sits at the top.
                    d.sh   = start_tx << (LEN_W'(MAX_WORD) - start_cfg.len);
                    d.rx   = '0;
                    d.sclk = start_cfg.cpol;
                    d.busy = 1'b1;
                end
            end
            ST_SETUP: begin
                d.st   = ST_SHIFT;
                d.hcnt = q.half;
            end
            ST_SHIFT: begin
                if (q.hcnt == '0) begin
                    d.hcnt = q.half;
                    d.sclk = ~q.sclk;
                    d.ecnt = q.ecnt + 1'b1;
                    if (q.ecnt[0] == q.cpha) begin
                        d.rx = {q.rx[MAX_WORD-2:0], miso};
                    end else if (q.ecnt != '0) begin
                        d.sh = q.sh << 1;
                    end
                    if (d.ecnt == {q.len, 1'b0}) begin
                        d.st = ST_END;
                    end
                end else begin
                    d.hcnt = q.hcnt - 1'b1;
                end
            end
            ST_END: begin
                if (q.hcnt == '0) begin
                    d.st   = ST_IDLE;
                    d.busy = 1'b0;
                    d.done = 1'b1;
                    d.rxo  = q.rx;
                end else begin
                    d.hcnt = q.hcnt - 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign cs_act  = (q.st == ST_SHIFT) || (q.st == ST_END);
    assign cs_sel  = q.sel;
    assign mosi    = cs_act && q.sh[MAX_WORD-1];
    assign sclk    = q.sclk;
    assign busy    = q.busy;
    assign done    = q.done;
    assign rx_data = q.rxo;

endmodule

// File: rtl/spi_multi_master.sv
module spi_multi_master
    import spi_mm_pkg::*;
#(
    parameter int N_SLV = 4,
    parameter int DIV_W = 8,
    localparam int SEL_W = (N_SLV > 1) ? $clog2(N_SLV) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic                cfg_cpol,
    input  logic                cfg_cpha,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic                req,
    input  logic [SEL_W-1:0]    req_sel,
    input  logic [MAX_WORD-1:0] req_tx,
    input  logic [DIV_W-1:0]    clk_div,
    input  logic                miso,
    output logic                sclk,
    output logic                mosi,
    output logic [N_SLV-1:0]    cs_n,
    output logic                busy,
    output logic                done,
    output logic [MAX_WORD-1:0] rx_data
);

    slv_cfg_t         wr_cfg;
    slv_cfg_t         tgt_cfg;
    logic             start;
    logic             cs_act;
    logic [SEL_W-1:0] cs_sel;

    assign wr_cfg = '{cpol: cfg_cpol, cpha: cfg_cpha, len: cfg_len};
    assign start  = req && !busy;

    spi_mm_cfg_tbl #(
        .N_SLV (N_SLV),
        .SEL_W (SEL_W)
    ) u_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wsel  (cfg_sel),
        .wcfg  (wr_cfg),
        .rsel  (req_sel),
        .rcfg  (tgt_cfg)
    );

    spi_mm_engine #(
        .SEL_W (SEL_W),
        .DIV_W (DIV_W)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_sel (req_sel),
        .start_cfg (tgt_cfg),
        .start_tx  (req_tx),
        .start_div (clk_div),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .busy      (busy),
        .done      (done),
        .rx_data   (rx_data),
        .cs_act    (cs_act),
        .cs_sel    (cs_sel)
    );

    spi_mm_csdec #(
        .N_SLV (N_SLV),
        .SEL_W (SEL_W)
    ) u_cs (
        .act  (cs_act),
        .sel  (cs_sel),
        .cs_n (cs_n)
    );

endmodule

// File: rtl/spi_mm_chk.sv
module spi_mm_chk #(
    parameter int N_SLV = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SLV-1:0] cs_n,
    input logic             sclk,
    input logic             busy,
    input logic             done
);

    // R3
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R3
    cs_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cs_n) |-> busy);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (&cs_n && done));

    // R9
    sclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n && &($past(cs_n)) && !$rose(busy)) |-> $stable(sclk));

    // R8
    target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&cs_n) && !(&($past(cs_n)))) |-> (cs_n == $past(cs_n)));

endmodule

bind spi_multi_master spi_mm_chk #(.N_SLV(N_SLV)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .sclk  (sclk),
    .busy  (busy),
    .done  (done)
);

// File: tb/tb_spi_multi_master.sv
module tb_spi_multi_master;

    localparam int NS = 4;
    localparam int DW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic        cfg_cpol = 1'b0;
    logic        cfg_cpha = 1'b0;
    logic [4:0]  cfg_len = '0;
    logic        req = 1'b0;
    logic [1:0]  req_sel = '0;
    logic [15:0] req_tx = '0;
    logic [DW-1:0] clk_div = '0;
    logic        miso = 1'b0;
    logic        sclk, mosi, busy, done;
    logic [NS-1:0] cs_n;
    logic [15:0] rx_data;

    always #2 clk = ~clk;

    spi_multi_master #(.N_SLV(NS), .DIV_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_len(cfg_len),
        .req(req), .req_sel(req_sel), .req_tx(req_tx), .clk_div(clk_div),
        .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy),
        .done(done), .rx_data(rx_data)
    );

    typedef struct {
        logic [NS-1:0] csn;
        logic          sclk;
        logic          mosi;
        logic          busy;
        logic          done;
        logic [15:0]   rx;
        logic          miso;
    } exp_t;

    exp_t  q[$];
    int    total = 0;
    int    bad = 0;
    bit    ended = 0;
    string ctx = "R1";
    int    m_cpol[NS];
    int    m_cpha[NS];
    int    m_len[NS];
    logic  last_cpol = 1'b0;
    logic [15:0] last_rx = '0;
    logic  exp_busy = 1'b0;
    logic [15:0] m_stx = '0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", tag, ctx, act, exp, $time);
        end
    endtask

    // Reference: full expected waveform of one accepted transfer.
    task automatic build();
        int   h = int'(clk_div) + 1;
        int   s = int'(req_sel);
        int   len = m_len[s];
        logic cp = logic'(m_cpol[s]);
        int   ph = m_cpha[s];
        int   kend = 2 + h * (2 * len + 1);
        logic [15:0] erx = 16'(m_stx & ((32'd1 << len) - 1));
        exp_t e;
        e.csn = '1; e.sclk = cp; e.mosi = 1'b0; e.busy = 1'b1;
        e.done = 1'b0; e.rx = last_rx; e.miso = 1'b0;
        q.push_back(e);
        for (int k = 2; k < kend; k++) begin
            int n = (k - 2) / h;
            int sh;
            if (n > 2 * len) n = 2 * len;
            if (ph == 0) sh = n / 2;
            else sh = (n == 0) ? 0 : (n - 1) / 2;
            e.csn = '1;
            e.csn[s] = 1'b0;
            e.sclk = cp ^ logic'(n % 2);
            e.mosi = (sh < len) ? req_tx[len - 1 - sh] : 1'b0;
            e.miso = (sh < len) ? m_stx[len - 1 - sh] : 1'b0;
            e.busy = 1'b1; e.done = 1'b0; e.rx = last_rx;
            q.push_back(e);
        end
        e.csn = '1; e.sclk = cp; e.mosi = 1'b0; e.busy = 1'b0;
        e.done = 1'b1; e.rx = erx; e.miso = 1'b0;
        q.push_back(e);
        last_cpol = cp;
        last_rx = erx;
    endtask

    task automatic cyc();
        exp_t e;
        if (req && !exp_busy) build();
        if (cfg_we) begin
            int l = int'(cfg_len);
            if (l < 4) l = 4;
            if (l > 16) l = 16;
            m_cpol[cfg_sel] = int'(cfg_cpol);
            m_cpha[cfg_sel] = int'(cfg_cpha);
            m_len[cfg_sel] = l;
        end
        @(negedge clk);
        if (q.size() > 0) begin
            e = q.pop_front();
        end else begin
            e.csn = '1; e.sclk = last_cpol; e.mosi = 1'b0; e.busy = 1'b0;
            e.done = 1'b0; e.rx = last_rx; e.miso = 1'b0;
        end
        check("R3", 32'(cs_n), 32'(e.csn));
        check("R4", 32'(sclk), 32'(e.sclk));
        check("R5", 32'(mosi), 32'(e.mosi));
        check("R7", 32'(busy), 32'(e.busy));
        check("R7", 32'(done), 32'(e.done));
        check("R6", 32'(rx_data), 32'(e.rx));
        miso = e.miso;
        exp_busy = e.busy;
    endtask

    task automatic write_cfg(int s, logic cp, logic ph, int len);
        cfg_we = 1'b1; cfg_sel = 2'(s); cfg_cpol = cp; cfg_cpha = ph; cfg_len = 5'(len);
        cyc();
        cfg_we = 1'b0;
    endtask

    task automatic drain();
        while (q.size() > 0) cyc();
        cyc();
    endtask

    task automatic xfer(int s, logic [15:0] tx, logic [15:0] stx, int div);
        req = 1'b1; req_sel = 2'(s); req_tx = tx; clk_div = DW'(div); m_stx = stx;
        cyc();
        req = 1'b0;
        drain();
    endtask

    initial begin
        for (int i = 0; i < NS; i++) begin
            m_cpol[i] = 0; m_cpha[i] = 0; m_len[i] = 16;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", 32'(cs_n), 32'hF);
        check("R1", 32'(sclk), 0);
        check("R1", 32'(mosi), 0);
        check("R1", 32'(busy), 0);
        check("R1", 32'(done), 0);
        check("R1", 32'(rx_data), 0);
        rst_n = 1'b1;
        cyc();

        // R2: reset entry is mode 0, 16 bits; ratio 2 (R4)
        ctx = "R2 default entry";
        xfer(0, 16'hA5C3, 16'h3C5A, 0);

        ctx = "R2 writes";
        write_cfg(1, 1'b0, 1'b1, 8);
        write_cfg(2, 1'b1, 1'b0, 12);
        write_cfg(3, 1'b1, 1'b1, 2);
        write_cfg(0, 1'b1, 1'b1, 20);

        ctx = "R5 mode1 len8";
        xfer(1, 16'hFF96, 16'h00C9, 1);
        ctx = "R5 mode2 len12";
        xfer(2, 16'h0ABC, 16'h0F31, 3);
        ctx = "R2 clamp low mode3";
        xfer(3, 16'h000B, 16'h0006, 2);
        ctx = "R2 clamp high mode3";
        xfer(0, 16'h8001, 16'hE71D, 0);
        ctx = "R6 upper tx bits";
        xfer(1, 16'hA53C, 16'h0081, 0);

        // R8: requests to other slaves while busy
        ctx = "R8 busy ignore";
        req = 1'b1; req_sel = 2'd2; req_tx = 16'h0555; clk_div = 8'd1; m_stx = 16'h0AAA;
        cyc();
        req_sel = 2'd1; req_tx = 16'h00FF; clk_div = 8'd0;
        repeat (10) cyc();
        req = 1'b0;
        drain();

        // Held request: next one accepted in the done cycle
        ctx = "R7 back-to-back";
        req = 1'b1; req_sel = 2'd3; req_tx = 16'h000C; clk_div = 8'd0; m_stx = 16'h0005;
        cyc();
        while (exp_busy) cyc();
        req_sel = 2'd1; req_tx = 16'h0042; m_stx = 16'h00B7;
        cyc();
        req = 1'b0;
        drain();

        // R2: write in the same cycle as a request uses the old entry
        ctx = "R2 same-cycle write";
        cfg_we = 1'b1; cfg_sel = 2'd2; cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_len = 5'd5;
        req = 1'b1; req_sel = 2'd2; req_tx = 16'h0123; clk_div = 8'd0; m_stx = 16'h0FED;
        cyc();
        cfg_we = 1'b0; req = 1'b0;
        drain();
        ctx = "R9 new entry";
        xfer(2, 16'h0013, 16'h000E, 1);
        repeat (4) cyc();

        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++;
            bad++;
            $display("FAIL watchdog R7 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule